// File: doc/BRIEF.md
# PDM Microphone Interface Emulator

This block models the digital side of a pulse-density-modulated microphone as synthesizable logic, for a verification platform or an FPGA that must stand in for a real microphone. It runs on a free-running reference clock and watches the bit clock that a receiver supplies. It takes one-bit modulator samples from an upstream source and places each one on a shared data line during the half of the bit-clock period assigned to its channel. Outside that half it releases the line, so that a second device on the other channel can use it.

The pad is formed outside the block: `pdm_dat_o` is the value to drive and `pdm_oe_o` enables the driver. When `pdm_oe_o` is low the line is high impedance. The channel strap selects which half is used. A low strap gives the right channel, which drives in the low half of the bit clock. A high strap gives the left channel, which drives in the high half. The launch and release points are each delayed by a parameter number of reference ticks, so the emulator can stress a receiver's sampling margin.

The block watches the bit clock for activity. When no bit-clock transition arrives for a parameter number of reference ticks (the 1 kHz-equivalent period), the device goes to sleep and releases the line. After reset or after sleep, it counts a fixed number of bit-clock rising edges (32,768 by default) before it drives again. The modulator samples arrive on a valid/ready stream. The only back-pressure is that the source waits for `s_ready_o`. `s_ready_o` pulses for one reference cycle at each slot launch while the device is awake, and that is the point where a bit is taken. The source holds `s_valid_i` and `s_data_i` until it sees the pulse. If no valid bit is present at a launch, the slot is filled from an alternating idle pattern, because an even ones density represents a zero-level signal.

Top module: `pdm_mic_emulator`

## Requirements
- R1: While reset is asserted and directly after it, `pdm_oe_o`, `pdm_dat_o` and `s_ready_o` are all 0.
- R2: After reset, and again after any sleep, `pdm_oe_o` stays 0 until WAKE_CYCLES rising bit-clock edges have been counted. The slot that follows the counting edge is the first one that may be driven.
- R3: With `chan_sel_i` = 0 (right channel), the line is driven during the low half of the bit clock, launched by the falling edge, and released after the next rising edge. The line is not driven during the high half.
- R4: With `chan_sel_i` = 1 (left channel), the line is driven during the high half, launched by the rising edge, and released after the falling edge. The line is not driven during the low half.
- R5: `pdm_oe_o` rises EN_DLY+4 reference cycles after the launching transition reaches `pdm_clk_i`, and falls DIS_DLY+4 reference cycles after the releasing transition. The delays include the two-stage synchronizer and one edge-detect stage.
- R6: `s_ready_o` is a one-cycle pulse, given only while awake and exactly once per launched slot. When `s_valid_i` is high at that pulse, `s_data_i` is the bit driven in that slot.
- R7: A slot launched with `s_valid_i` low carries the idle pattern. The pattern alternates 1, 0, 1, 0 across such slots, and its first slot after reset carries 1.
- R8: If no bit-clock transition arrives for SLEEP_TICKS reference cycles, the device sleeps. `pdm_oe_o` drops within two cycles, even in the middle of a driven half, and stays 0 while asleep.
- R9: `pdm_dat_o` holds one value for the whole time `pdm_oe_o` is high.
- R10: `pdm_dat_o` is 0 whenever `pdm_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdm_clk_i | input | 1 | Bit clock from the receiver (asynchronous) |
| chan_sel_i | input | 1 | Channel strap: 0 right (low half), 1 left (high half) |
| s_valid_i | input | 1 | Modulator sample present |
| s_data_i | input | 1 | Modulator sample bit |
| s_ready_o | output | 1 | One-cycle pulse when a sample is taken |
| pdm_dat_o | output | 1 | Value for the data pad |
| pdm_oe_o | output | 1 | Data pad driver enable (0 = high impedance) |

## Verification
The bench builds the block with WAKE_CYCLES = 8, SLEEP_TICKS = 100, EN_DLY = 2 and DIS_DLY = 1, and uses a bit clock with a 20-tick period. The short wake count makes it possible to check the full startup gate twice, once after reset and once after a sleep. The short timeout lets the bench stop the clock in the middle of a driven half and watch the forced release. The unequal delays let the bench tell the launch timing apart from the release timing, cycle by cycle.

// File: rtl/pdm_emu_pkg.sv
package pdm_emu_pkg;

  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } bclk_evt_t;

endpackage

// File: rtl/pdm_edge_sync.sv
module pdm_edge_sync
  import pdm_emu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  output bclk_evt_t evt_o
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], pin_i};
  end

  assign evt_o.rise =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign evt_o.fall = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];
endmodule

// File: rtl/pdm_activity.sv
module pdm_activity
  import pdm_emu_pkg::*;
#(
  parameter int SLEEP_TICKS = 100000,
  parameter int WAKE_CYCLES = 32768
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bclk_evt_t evt_i,
  output logic      active_o
);
  localparam int IDLE_W = (SLEEP_TICKS > 1) ? $clog2(SLEEP_TICKS) : 1;
  localparam int WAKE_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(SLEEP_TICKS - 1);
  localparam logic [WAKE_W-1:0] WAKE_LIM = WAKE_W'(WAKE_CYCLES - 1);

  logic [IDLE_W-1:0] idle_q;
  logic [WAKE_W-1:0] wake_q;
  logic              any_edge;
  logic              timeout;

  assign any_edge = evt_i.rise | evt_i.fall;
  assign timeout  = (idle_q == IDLE_LIM) && !any_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (any_edge) begin
      idle_q <= '0;
    end else if (idle_q != IDLE_LIM) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      wake_q   <= '0;
    end else if (timeout) begin
      active_o <= 1'b0;
      wake_q   <= '0;
    end else if (!active_o && evt_i.rise) begin
      if (wake_q == WAKE_LIM) begin
        active_o <= 1'b1;
        wake_q   <= '0;
      end else begin
        wake_q <= wake_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdm_slot_driver.sv
module pdm_slot_driver
  import pdm_emu_pkg::*;
#(
  parameter int EN_DLY  = 0,
  parameter int DIS_DLY = 0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bclk_evt_t evt_i,
  input  chan_e     chan_i,
  input  logic      active_i,
  input  logic      s_valid_i,
  input  logic      s_data_i,
  output logic      s_ready_o,
  output logic      dat_o,
  output logic      oe_o
);
  localparam int MAX_DLY = (EN_DLY > DIS_DLY) ? EN_DLY : DIS_DLY;
  localparam int DLY_W   = (MAX_DLY > 0) ? $clog2(MAX_DLY + 1) : 1;
  localparam logic [DLY_W-1:0] EN_LD  = DLY_W'(EN_DLY);
  localparam logic [DLY_W-1:0] DIS_LD = DLY_W'(DIS_DLY);

  logic             launch;
  logic             release_ev;
  logic             en_pend_q, dis_pend_q;
  logic [DLY_W-1:0] en_cnt_q, dis_cnt_q;
  logic             bit_q;
  logic             alt_q;

  assign launch     = active_i && ((chan_i == CH_LEFT) ? evt_i.rise : evt_i.fall);
  assign release_ev = (chan_i == CH_LEFT) ? evt_i.fall : evt_i.rise;
  assign s_ready_o  = launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_o       <= 1'b0;
      dat_o      <= 1'b0;
      en_pend_q  <= 1'b0;
      dis_pend_q <= 1'b0;
      en_cnt_q   <= '0;
      dis_cnt_q  <= '0;
      bit_q      <= 1'b0;
      alt_q      <= 1'b1;
    end else if (!active_i) begin
      oe_o       <= 1'b0;
      dat_o      <= 1'b0;
      en_pend_q  <= 1'b0;
      dis_pend_q <= 1'b0;
    end else begin
      if (launch) begin
        en_pend_q <= 1'b1;
        en_cnt_q  <= EN_LD;
        bit_q     <= s_valid_i ? s_data_i : alt_q;
        if (!s_valid_i) alt_q <= ~alt_q;
      end else if (en_pend_q) begin
        if (en_cnt_q == '0) begin
          en_pend_q <= 1'b0;
          oe_o      <= 1'b1;
          dat_o     <= bit_q;
        end else begin
          en_cnt_q <= en_cnt_q - 1'b1;
        end
      end
      if (release_ev) begin
        dis_pend_q <= 1'b1;
        dis_cnt_q  <= DIS_LD;
      end else if (dis_pend_q) begin
        if (dis_cnt_q == '0) begin
          dis_pend_q <= 1'b0;
          oe_o       <= 1'b0;
          dat_o      <= 1'b0;
        end else begin
          dis_cnt_q <= dis_cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pdm_mic_emulator.sv
module pdm_mic_emulator
  import pdm_emu_pkg::*;
#(
  parameter int SLEEP_TICKS = 100000,
  parameter int WAKE_CYCLES = 32768,
  parameter int EN_DLY      = 4,
  parameter int DIS_DLY     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdm_clk_i,
  input  logic chan_sel_i,
  input  logic s_valid_i,
  input  logic s_data_i,
  output logic s_ready_o,
  output logic pdm_dat_o,
  output logic pdm_oe_o
);
  bclk_evt_t evt_w;
  logic      active_w;

  pdm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pdm_clk_i),
    .evt_o (evt_w)
  );

  pdm_activity #(.SLEEP_TICKS(SLEEP_TICKS), .WAKE_CYCLES(WAKE_CYCLES)) u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_w),
    .active_o (active_w)
  );

  pdm_slot_driver #(.EN_DLY(EN_DLY), .DIS_DLY(DIS_DLY)) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_w),
    .chan_i    (chan_e'(chan_sel_i)),
    .active_i  (active_w),
    .s_valid_i (s_valid_i),
    .s_data_i  (s_data_i),
    .s_ready_o (s_ready_o),
    .dat_o     (pdm_dat_o),
    .oe_o      (pdm_oe_o)
  );
endmodule

// File: rtl/pdm_mic_emulator_chk.sv
module pdm_mic_emulator_chk (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic s_ready,
  input logic dat,
  input logic oe
);
  AST_ASLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && $past(!active)) |-> !oe); // R8

  AST_SLEEP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |=> !oe); // R8

  AST_READY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> active); // R6

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready); // R6

  AST_DAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe)) |-> $stable(dat)); // R9

  AST_DAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dat); // R10
endmodule

bind pdm_mic_emulator pdm_mic_emulator_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .active  (active_w),
  .s_ready (s_ready_o),
  .dat     (pdm_dat_o),
  .oe      (pdm_oe_o)
);

// File: tb/test_pdm_mic_emulator.sv
module test_pdm_mic_emulator;
  localparam int SLEEP_T = 100;
  localparam int WAKE_N  = 8;
  localparam int HALF    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pdm_clk = 1'b0;
  logic chan_sel = 1'b0;
  logic s_valid = 1'b0;
  logic s_data = 1'b0;
  logic s_ready, pdm_dat, pdm_oe;

  int checks = 0;
  int errors = 0;
  int ready_cnt = 0;
  int oe_cnt = 0;
  logic hi_oe, hi_dat, lo_oe, lo_dat;

  always #5 clk = ~clk;

  pdm_mic_emulator #(
    .SLEEP_TICKS(SLEEP_T), .WAKE_CYCLES(WAKE_N), .EN_DLY(2), .DIS_DLY(1)
  ) i_pdm_mic_emulator (
    .clk(clk), .rst_n(rst_n), .pdm_clk_i(pdm_clk), .chan_sel_i(chan_sel),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .pdm_dat_o(pdm_dat), .pdm_oe_o(pdm_oe)
  );

  always @(posedge clk) begin
    if (rst_n && s_ready) ready_cnt <= ready_cnt + 1;
    if (rst_n && pdm_oe)  oe_cnt    <= oe_cnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_bclk(input logic lvl);
    @(negedge clk);
    pdm_clk = lvl;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // one half period of HALF ticks, sampling the pad near its end
  task automatic half_cycle(input logic lvl, output logic s_oe, output logic s_dat);
    drive_bclk(lvl);
    ticks(HALF - 2);
    s_oe  = pdm_oe;
    s_dat = pdm_dat;
    ticks(1);
  endtask

  task automatic bit_cycle();
    half_cycle(1'b1, hi_oe, hi_dat);
    half_cycle(1'b0, lo_oe, lo_dat);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ticks(3);
    check("R1 oe in reset", int'(pdm_oe), 0);
    check("R1 ready in reset", int'(s_ready), 0);
    rst_n = 1'b1;
    ticks(2);
    check("R1 oe after reset", int'(pdm_oe), 0);
    check("R1 dat after reset", int'(pdm_dat), 0);
  endtask

  task automatic t_wake_right();
    oe_cnt = 0;
    for (int i = 0; i < WAKE_N - 1; i++) bit_cycle();
    check("R2 no drive during wake", oe_cnt, 0);
    bit_cycle();
    check("R3 right drives low half", int'(lo_oe), 1);
    check("R3 right idle in high half", int'(hi_oe), 0);
    check("R7 first idle bit", int'(lo_dat), 1);
  endtask

  task automatic t_idle_pattern();
    logic exp_bit = 1'b0;
    for (int i = 0; i < 3; i++) begin
      bit_cycle();
      check("R7 idle alternation", int'(lo_dat), int'(exp_bit));
      check("R10 dat low when released", int'(hi_dat), 0);
      exp_bit = ~exp_bit;
    end
  endtask

  task automatic t_stream(input logic [5:0] bits, input bit left);
    int r0 = ready_cnt;
    s_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      s_data = bits[i];
      bit_cycle();
      if (left) begin
        check("R6 left stream bit", int'(hi_dat), int'(bits[i]));
        check("R4 left oe high half", int'(hi_oe), 1);
        check("R4 left quiet low half", int'(lo_oe), 0);
      end else begin
        check("R6 right stream bit", int'(lo_dat), int'(bits[i]));
      end
    end
    check("R6 one ready per slot", ready_cnt - r0, 6);
    s_valid = 1'b0;
  endtask

  task automatic t_timing();
    logic held;
    half_cycle(1'b1, hi_oe, hi_dat);
    drive_bclk(1'b0);
    ticks(5);
    check("R5 enable not yet", int'(pdm_oe), 0);
    ticks(1);
    check("R5 enable at EN_DLY+4", int'(pdm_oe), 1);
    held = pdm_dat;
    ticks(3);
    check("R9 data held", int'(pdm_dat), int'(held));
    drive_bclk(1'b1);
    ticks(4);
    check("R5 release not yet", int'(pdm_oe), 1);
    ticks(1);
    check("R5 release at DIS_DLY+4", int'(pdm_oe), 0);
    ticks(4);
    half_cycle(1'b0, lo_oe, lo_dat);
  endtask

  task automatic t_sleep();
    half_cycle(1'b1, hi_oe, hi_dat);
    drive_bclk(1'b0);
    ticks(HALF - 2);
    check("R8 driving before stop", int'(pdm_oe), 1);
    ticks(SLEEP_T - 20);
    check("R8 still awake before timeout", int'(pdm_oe), 1);
    ticks(30);
    check("R8 released on sleep", int'(pdm_oe), 0);
    ticks(50);
    check("R8 stays released", int'(pdm_oe), 0);
  endtask

  task automatic t_wake_left();
    chan_sel = 1'b1;
    s_valid = 1'b1;
    s_data = 1'b0;
    oe_cnt = 0;
    for (int i = 0; i < WAKE_N; i++) bit_cycle();
    check("R2 no drive during re-wake", oe_cnt, 0);
    s_valid = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_wake_right();
    t_idle_pattern();
    t_stream(6'b001011, 1'b0);
    t_timing();
    t_sleep();
    t_wake_left();
    t_stream(6'b110100, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule